// File: doc/BRIEF.md
# Open-Drain Two-Line Pin Controller

This block owns two general-purpose pins, a clock line and a data line, and lets software bit-bang a two-wire serial bus through them. The pins behave as open-drain outputs. The output value of each pin is held at zero. Software pulls a line low by setting that pin's output enable, and releases the line to its pull-up by clearing the enable. Line levels are sampled back through a two-flop synchronizer, so software can follow clock stretching and read acknowledge bits.

A small write/read register port reaches four registers: an ownership mask, a drive register, the ownership state and the synchronized line levels. Writes to the mask and drive registers carry a per-pin select field. Only the selected bits change. When software claims a pin, an ownership state machine walks through a fixed sequence before any drive write is accepted:

- **IDLE**: no pin is claimed.
- **CLR_VAL**: one cycle in which both output values are confirmed at zero.
- **CLR_EN**: one cycle in which both enables are cleared.
- **OWNED**: drive writes are accepted.

The transitions are:

- **claim**: IDLE to CLR_VAL, when a mask write leaves any bit set.
- **values cleared**: CLR_VAL to CLR_EN.
- **inputs set**: CLR_EN to OWNED.
- **release**: any state to IDLE, when the mask becomes all zero.

Top module: `od_gpio_pair`

## Requirements
- R1: After reset, the following all read 0: the mask register (address 0), the drive register (address 1), the state register (address 2) and `line_oe`.
- R2: A mask write that leaves a mask bit set while in IDLE moves the state register through the codes 1 (CLR_VAL), 2 (CLR_EN) and 3 (OWNED) on three successive clock edges. The first step happens on the edge of the write.
- R3: Drive writes to address 1 use bits [3:2] as a pin select (bit 2 for the clock line, bit 3 for the data line) and bits [1:0] as levels. In OWNED, writing level 0 to a selected pin whose mask bit is set sets that pin's enable. `line_oe` then goes high on that edge and the line is pulled low.
- R4: In OWNED, writing level 1 to a selected, masked pin clears its enable, so the line floats high.
- R5: A drive write is ignored for any pin whose mask bit is clear, and for all pins outside OWNED.
- R6: Mask and drive writes change only the bits named in the select field. All other bits of the register keep their value.
- R7: Address 3 returns each line's level through two flops. A line change is visible after the second rising edge, and not after the first. A released line reads 1 and a pulled-low line reads 0.
- R8: Clearing a mask bit clears that pin's enable on the same edge. When the whole mask becomes zero, the state returns to IDLE (code 0).
- R9: `line_out` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 mask, 1 drive, 2 state, 3 levels |
| reg_wdata | input | 8 | Write data: [3:2] pin select, [1:0] values |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| line_in | input | 2 | Raw line levels (bit 0 clock, bit 1 data) |
| line_oe | output | 2 | Per-pin output enable; 1 pulls the line low |
| line_out | output | 2 | Per-pin output value, held at 0 |

## Verification
The bench tries every 4-bit select/level combination on the drive register under each of the four mask settings. A running expected enable vector is computed arithmetically for each write. This separates three cases: bits that must flip, bits that select leaves alone, and bits that an unmasked pin must ignore. After each drive write, the bench checks the line level read back through the synchronizer. This confirms that the register state really reaches the wired-AND bus and returns with a lag of exactly two edges. Separate patterns cover the claim sequence one edge at a time, a partial mask clear, an external device pulling a released line low, and drive writes made in IDLE.

// File: rtl/od_gpio_pkg.sv
package od_gpio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CLR_VAL = 2'd1,
        ST_CLR_EN  = 2'd2,
        ST_OWNED   = 2'd3
    } own_state_t;

    localparam logic [1:0] ADDR_MASK  = 2'd0;
    localparam logic [1:0] ADDR_DRIVE = 2'd1;
    localparam logic [1:0] ADDR_STATE = 2'd2;
    localparam logic [1:0] ADDR_LEVEL = 2'd3;

endpackage

// File: rtl/od_gpio_fsm.sv
module od_gpio_fsm
    import od_gpio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mask_any_nxt,
    output own_state_t state_q,
    output logic       drive_ok,
    output logic       en_clr
);

    own_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (mask_any_nxt) state_d = ST_CLR_VAL;
            ST_CLR_VAL: state_d = mask_any_nxt ? ST_CLR_EN : ST_IDLE;
            ST_CLR_EN:  state_d = mask_any_nxt ? ST_OWNED  : ST_IDLE;
            ST_OWNED:   if (!mask_any_nxt) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        drive_ok = 1'b0;
        en_clr   = 1'b0;
        unique case (state_q)
            ST_IDLE:    en_clr = 1'b1;
            ST_CLR_VAL: ;
            ST_CLR_EN:  en_clr = 1'b1;
            ST_OWNED:   drive_ok = 1'b1;
        endcase
    end

    AST_CLAIM_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (state_q == ST_IDLE || state_q == ST_CLR_VAL)); // R2
    AST_VAL_BEFORE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLR_VAL) |=> (state_q != ST_OWNED)); // R2

endmodule

// File: rtl/od_gpio_regs.sv
module od_gpio_regs
    import od_gpio_pkg::*;
#(
    parameter int NPINS = 2,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [DW-1:0]    wdata,
    input  logic             drive_ok,
    input  logic             en_clr,
    output logic [NPINS-1:0] mask_q,
    output logic [NPINS-1:0] en_q,
    output logic             mask_any_nxt
);

    logic [NPINS-1:0] sel, val, wbits, mask_d, en_d;

    assign sel = wdata[NPINS +: NPINS];
    assign val = wdata[NPINS-1:0];

    always_comb begin
        mask_d = mask_q;
        if (we && addr == ADDR_MASK)
            mask_d = (mask_q & ~sel) | (val & sel);
        wbits = (we && addr == ADDR_DRIVE && drive_ok) ? (sel & mask_q) : '0;
        en_d  = (en_q & ~wbits) | (~val & wbits);
        if (en_clr) en_d = '0;
        en_d = en_d & mask_d;
    end

    assign mask_any_nxt = |mask_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            en_q   <= '0;
        end else begin
            mask_q <= mask_d;
            en_q   <= en_d;
        end
    end

    AST_EN_WITHIN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_q & ~mask_q) == '0)); // R8
    AST_NO_SET_UNOWNED: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive_ok) |=> ((en_q & ~$past(en_q)) == '0)); // R5
    AST_MASK_RMW: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_MASK) |=>
        ((mask_q & ~$past(wdata[NPINS +: NPINS])) == ($past(mask_q) & ~$past(wdata[NPINS +: NPINS])))); // R6

endmodule

// File: rtl/od_gpio_sync.sv
module od_gpio_sync #(
    parameter int NPINS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] raw,
    output logic [NPINS-1:0] synced
);

    logic [NPINS-1:0] stage1;
    logic [1:0]       warm_q;

    genvar g;
    generate
        for (g = 0; g < NPINS; g++) begin : g_pin
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage1[g] <= 1'b1;
                    synced[g] <= 1'b1;
                end else begin
                    stage1[g] <= raw[g];
                    synced[g] <= stage1[g];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    AST_SYNC_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2) |-> (synced == $past(raw, 2))); // R7

endmodule

// File: rtl/od_gpio_pair.sv
module od_gpio_pair
    import od_gpio_pkg::*;
#(
    parameter int NPINS = 2,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic [NPINS-1:0] line_in,
    output logic [NPINS-1:0] line_oe,
    output logic [NPINS-1:0] line_out
);

    localparam int PADW = DW - NPINS;

    own_state_t       state_q;
    logic             drive_ok, en_clr, mask_any_nxt;
    logic [NPINS-1:0] mask_q, en_q, level_q;

    od_gpio_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mask_any_nxt (mask_any_nxt),
        .state_q      (state_q),
        .drive_ok     (drive_ok),
        .en_clr       (en_clr)
    );

    od_gpio_regs #(.NPINS(NPINS), .DW(DW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (reg_we),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .drive_ok     (drive_ok),
        .en_clr       (en_clr),
        .mask_q       (mask_q),
        .en_q         (en_q),
        .mask_any_nxt (mask_any_nxt)
    );

    od_gpio_sync #(.NPINS(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (line_in),
        .synced (level_q)
    );

    assign line_oe  = en_q;
    assign line_out = '0;

    always_comb begin
        unique case (reg_addr)
            ADDR_MASK:  reg_rdata = {{PADW{1'b0}}, mask_q};
            ADDR_DRIVE: reg_rdata = {{PADW{1'b0}}, en_q};
            ADDR_STATE: reg_rdata = {{(DW-2){1'b0}}, state_q};
            ADDR_LEVEL: reg_rdata = {{PADW{1'b0}}, level_q};
        endcase
    end

    AST_DRIVE_ONLY_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe != '0) |-> (state_q == ST_OWNED)); // R5

endmodule

// File: tb/od_gpio_pair_bench.sv
module od_gpio_pair_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [1:0] line_oe, line_out, line_in;
    logic [1:0] ext_rel = 2'b11;   // external device: 0 pulls that line low

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;   // 125 MHz

    // wired-AND bus with pull-ups
    assign line_in = ~(line_oe & ~line_out) & ext_rel;

    od_gpio_pair u_od_gpio_pair (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_in(line_in),
        .line_oe(line_oe), .line_out(line_out)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    initial begin
        int v;
        int exp_en;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, v); check("R1 mask", v, 0);
        rd(2'd1, v); check("R1 drive", v, 0);
        rd(2'd2, v); check("R1 state", v, 0);
        check("R1 oe", int'(line_oe), 0);
        check("R9 out", int'(line_out), 0);
        // R5: drive write in IDLE ignored
        wr(2'd1, 8'h0C);
        rd(2'd1, v); check("R5 idle drive", v, 0);
        check("R5 idle oe", int'(line_oe), 0);
        // R2: claim sequence, one edge at a time
        wr(2'd0, 8'h0F);
        rd(2'd2, v); check("R2 clr_val", v, 1);
        @(negedge clk); rd(2'd2, v); check("R2 clr_en", v, 2);
        @(negedge clk); rd(2'd2, v); check("R2 owned", v, 3);
        // R5: drive write during claim is ignored
        wr(2'd0, 8'h0C);
        wr(2'd0, 8'h0F);
        wr(2'd1, 8'h0C);   // lands in CLR_EN
        rd(2'd1, v); check("R5 claim drive", v, 0);

        // sweep all mask settings and all drive writes
        for (int m = 0; m < 4; m++) begin
            wr(2'd0, 8'h0C);
            rd(2'd2, v); check("R8 idle", v, 0);
            rd(2'd1, v); check("R8 drive cleared", v, 0);
            if (m != 0) begin
                wr(2'd0, 8'(12 | m));
                @(negedge clk); @(negedge clk);
                rd(2'd2, v); check("R2 owned sweep", v, 3);
            end
            exp_en = 0;
            for (int d = 0; d < 16; d++) begin
                int sel, lv, wb;
                string tag;
                sel = (d >> 2) & 3;
                lv  = d & 3;
                wb  = sel & m;
                exp_en = ((exp_en & ~wb) | (~lv & wb)) & 3;
                if (wb != sel)        tag = "R5";
                else if ((lv & wb) != 0) tag = "R4";
                else                  tag = "R3";
                wr(2'd1, 8'(d));
                rd(2'd1, v); check({tag, " drive reg (R6 select)"}, v, exp_en);
                check({tag, " line_oe"}, int'(line_oe), exp_en);
                check("R9 line_out", int'(line_out), 0);
                @(negedge clk); @(negedge clk);
                rd(2'd3, v); check("R7 level", v, (~exp_en) & 3);
            end
        end

        // R6: partial mask clear; R8: cleared pin released
        wr(2'd0, 8'h0C); wr(2'd0, 8'h0F);
        @(negedge clk); @(negedge clk);
        wr(2'd1, 8'h0C);   // both lines low
        rd(2'd1, v); check("R3 both low", v, 3);
        wr(2'd0, 8'h04);   // clear clock-line mask only
        rd(2'd0, v); check("R6 mask rmw", v, 2);
        rd(2'd1, v); check("R8 pin released", v, 2);
        rd(2'd2, v); check("R8 still owned", v, 3);
        wr(2'd1, 8'h04);   // clock pin unmasked: ignored
        rd(2'd1, v); check("R5 unmasked pin", v, 2);
        wr(2'd0, 8'h08);   // clear data-line mask
        rd(2'd2, v); check("R8 to idle", v, 0);
        check("R8 oe released", int'(line_oe), 0);

        // R7: external pull, two-edge lag
        @(negedge clk); @(negedge clk);
        rd(2'd3, v); check("R7 high", v, 3);
        ext_rel = 2'b01;
        @(negedge clk);
        rd(2'd3, v); check("R7 one edge", v, 3);
        @(negedge clk);
        rd(2'd3, v); check("R7 two edges", v, 1);
        ext_rel = 2'b11;

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(8 * 200000);
        fails++; total++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule